// File: doc/BRIEF.md
# Event Router with Direct and Latched Modes

The event router gathers 27 event lines and turns them into two request outputs for an interrupt controller: an interrupt request and a wake-up request. Lines 0 to 23 come from external level-sensitive pins, such as receive-line activity on CAN, LIN or UART ports. Lines 24 to 26 are internal sources that are already in the block's clock domain. Each external line passes through a two-flop synchroniser before any other logic uses it.

A small register bus sets up each line. One bit picks direct mode, where the event follows its source level, or latched mode, where an edge detector sets a sticky pending bit. A polarity bit picks the active level or edge. Two masks pick which events feed the interrupt output and which feed the wake-up output. Software reads the synchronised levels and the pending bits, and clears pending bits by writing ones.

Top module: `event_router`

## Requirements
- R1: After reset every configuration register and every pending bit is zero, and `irq_o` and `wake_o` are low.
- R2: Lines 0 to 23 are taken from `ext_ev` through a two-flop synchroniser, and lines 24 to 26 are taken straight from `int_ev`. The raw register (address 4) shows these levels, so an external change appears there two clocks after it is sampled.
- R3: When mode bit i (address 0) is 0, line i is active while its level differs from polarity bit i (address 1): 0 means active high and 1 means active low. The event holds no state and drops as soon as the level turns inactive.
- R4: When mode bit i is 1, an edge on the line sets pending bit i (address 5). Polarity 0 selects a rising edge and polarity 1 a falling edge. The opposite edge does nothing. The bit stays set after the input returns.
- R5: A write to address 5 clears each pending bit whose write bit is 1. Write bits of 0 leave the pending bits unchanged.
- R6: If an edge that sets a pending bit and a write that clears it fall in the same cycle, the bit stays set.
- R7: `irq_o` is a register that goes high one clock after some line i has interrupt-enable bit i (address 2) set and is either pending or active in direct mode. It goes low one clock after no line meets this.
- R8: `wake_o` follows the same rule as R7, using the wake-enable mask at address 3.
- R9: Addresses 0 to 3 can be read and written. Addresses 4 and 5 return the raw levels and pending bits. Bits 27 to 31 and addresses 6 and 7 read as zero.
- R10: A line in direct mode never sets its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_ev | input | 24 | External event pins, asynchronous |
| int_ev | input | 3 | Internal event sources, synchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Combined wake-up request |

## Verification
The bench aims at the cases where the clock count matters:
- The raw level must appear exactly two clocks after the pin changes. A design with one synchroniser stage or three would be off by one.
- A single-cycle pulse must leave a pending bit set, and a design that latches the level instead of the edge would lose it.
- The wrong edge under falling polarity must be ignored. A design that ignored polarity would latch on the wrong edge.
- A clear write that coincides with a new edge must leave the bit set. A design that gave the clear priority would drop that event.
- Writing zeros to the pending register must do nothing. A design that cleared on any write would lose events.
- Removing an enable bit, or clearing the last pending bit, must drop the outputs exactly one clock later.

// File: rtl/er_pkg.sv
`timescale 1ns/1ps
package er_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MODE = 3'd0,
        SEL_POL  = 3'd1,
        SEL_IEN  = 3'd2,
        SEL_WEN  = 3'd3,
        SEL_RAW  = 3'd4,
        SEL_PEND = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/er_sync.sv
`timescale 1ns/1ps
module er_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d[s] = st_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q[STAGES-1];
endmodule

// File: rtl/er_regs.sv
`timescale 1ns/1ps
module er_regs
    import er_pkg::*;
#(
    parameter int N  = 27,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [N-1:0]      raw,
    input  logic [N-1:0]      pend,
    output logic [DW-1:0]     rdata,
    output logic [N-1:0]      mode,
    output logic [N-1:0]      pol,
    output logic [N-1:0]      ien,
    output logic [N-1:0]      wen,
    output logic [N-1:0]      clr
);
    typedef struct packed {
        logic [N-1:0] mode;
        logic [N-1:0] pol;
        logic [N-1:0] ien;
        logic [N-1:0] wen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DW-1:N];

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        if (we) begin
            case (addr)
                SEL_MODE: cfg_d.mode = wdata[N-1:0];
                SEL_POL:  cfg_d.pol  = wdata[N-1:0];
                SEL_IEN:  cfg_d.ien  = wdata[N-1:0];
                SEL_WEN:  cfg_d.wen  = wdata[N-1:0];
                SEL_PEND: clr        = wdata[N-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (addr)
            SEL_MODE: rdata = DW'(cfg_q.mode);
            SEL_POL:  rdata = DW'(cfg_q.pol);
            SEL_IEN:  rdata = DW'(cfg_q.ien);
            SEL_WEN:  rdata = DW'(cfg_q.wen);
            SEL_RAW:  rdata = DW'(raw);
            SEL_PEND: rdata = DW'(pend);
            default:  rdata = '0;
        endcase
    end

    assign mode = cfg_q.mode;
    assign pol  = cfg_q.pol;
    assign ien  = cfg_q.ien;
    assign wen  = cfg_q.wen;
endmodule

// File: rtl/er_latch.sv
`timescale 1ns/1ps
module er_latch #(
    parameter int N = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] ien,
    input  logic [N-1:0] wen,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] edge_o,
    output logic         irq_o,
    output logic         wake_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
        logic         irq;
        logic         wake;
    } st_t;

    st_t          st_d, st_q;
    logic [N-1:0] rise, fall, edge_sel, direct, live;

    always_comb begin
        rise     = lvl & ~st_q.prev;
        fall     = ~lvl & st_q.prev;
        edge_sel = (rise & ~pol) | (fall & pol);
        direct   = ~mode & (lvl ^ pol);
        live     = st_q.pend | direct;

        st_d      = st_q;
        st_d.prev = lvl;
        // a new edge overrides a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr) | (edge_sel & mode);
        st_d.irq  = |(live & ien);
        st_d.wake = |(live & wen);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign edge_o = edge_sel;
    assign irq_o  = st_q.irq;
    assign wake_o = st_q.wake;
endmodule

// File: rtl/event_router.sv
`timescale 1ns/1ps
module event_router
    import er_pkg::*;
#(
    parameter int N_EXT  = 24,
    parameter int N_INT  = 3,
    parameter int DW     = 32,
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_EXT-1:0]      ext_ev,
    input  logic [N_INT-1:0]      int_ev,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic                  irq_o,
    output logic                  wake_o
);
    localparam int N = N_EXT + N_INT;

    logic [N_EXT-1:0] ext_sync;
    logic [N-1:0]     lvl_w, mode_w, pol_w, ien_w, wen_w, clr_w, pend_w, edge_w;

    er_sync #(.W(N_EXT), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ext_ev),
        .sync_o (ext_sync)
    );

    assign lvl_w = {int_ev, ext_sync};

    er_regs #(.N(N), .DW(DW)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bus_we),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .raw  (lvl_w),
        .pend (pend_w),
        .rdata(bus_rdata),
        .mode (mode_w),
        .pol  (pol_w),
        .ien  (ien_w),
        .wen  (wen_w),
        .clr  (clr_w)
    );

    er_latch #(.N(N)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl_w),
        .mode  (mode_w),
        .pol   (pol_w),
        .ien   (ien_w),
        .wen   (wen_w),
        .clr   (clr_w),
        .pend_o(pend_w),
        .edge_o(edge_w),
        .irq_o (irq_o),
        .wake_o(wake_o)
    );
endmodule

// File: rtl/er_checker.sv
`timescale 1ns/1ps
module er_checker
    import er_pkg::*;
#(
    parameter int N = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [N-1:0]      mode,
    input logic [N-1:0]      ien,
    input logic [N-1:0]      wen,
    input logic [N-1:0]      pend,
    input logic [N-1:0]      edge_v,
    input logic              irq,
    input logic              wake
);
    p_hold_without_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == SEL_PEND) |=> ((pend & $past(pend)) == $past(pend)));

    p_direct_never_pends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(mode)) == '0));

    p_edge_sets_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_v & mode) != '0) |=> ((pend & $past(edge_v & mode)) == $past(edge_v & mode)));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |=> !irq);

    p_wake_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wen == '0) |=> !wake);
endmodule

bind event_router er_checker #(.N(N)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .mode  (mode_w),
    .ien   (ien_w),
    .wen   (wen_w),
    .pend  (pend_w),
    .edge_v(edge_w),
    .irq   (irq_o),
    .wake  (wake_o)
);

// File: tb/event_router_tb.sv
`timescale 1ns/1ps
module event_router_tb;
    localparam int N = 27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] ext_ev = '0;
    logic [2:0]  int_ev = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, wake_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    event_router u_dut (
        .clk(clk), .rst_n(rst_n), .ext_ev(ext_ev), .int_ev(int_ev),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .wake_o(wake_o)
    );

    // behavioural reference model
    logic [23:0]  m_s1, m_s2;
    logic [N-1:0] m_prev, m_pend, m_mode, m_pol, m_ien, m_wen;
    logic         m_irq, m_wake;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0;
            m_mode = '0; m_pol = '0; m_ien = '0; m_wen = '0;
            m_irq = 0; m_wake = 0;
        end else begin
            logic [N-1:0] lv, npend;
            logic nirq, nwake;
            lv = {int_ev, m_s2};
            nirq = 0; nwake = 0;
            for (int i = 0; i < N; i++) begin
                bit act, hit, edg, clear;
                act = !m_mode[i] && (lv[i] != m_pol[i]);
                hit = m_pend[i] || act;
                if (hit && m_ien[i]) nirq = 1;
                if (hit && m_wen[i]) nwake = 1;
                edg = m_pol[i] ? (m_prev[i] && !lv[i]) : (!m_prev[i] && lv[i]);
                clear = bus_we && bus_addr == 3'd5 && bus_wdata[i];
                if (m_mode[i] && edg) npend[i] = 1;
                else if (clear)       npend[i] = 0;
                else                  npend[i] = m_pend[i];
            end
            m_pend = npend; m_irq = nirq; m_wake = nwake;
            m_prev = lv; m_s2 = m_s1; m_s1 = ext_ev;
            if (bus_we) begin
                case (bus_addr)
                    3'd0: m_mode = bus_wdata[N-1:0];
                    3'd1: m_pol  = bus_wdata[N-1:0];
                    3'd2: m_ien  = bus_wdata[N-1:0];
                    3'd3: m_wen  = bus_wdata[N-1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R7 and R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 irq vs model", {31'd0, irq_o}, {31'd0, m_irq});
            chk("R8 wake vs model", {31'd0, wake_o}, {31'd0, m_wake});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_wdata = '0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 / R9 reset state
        for (int a = 0; a < 8; a++) rd("R1 reset register", 3'(a), 32'd0);
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        chk("R1 wake after reset", {31'd0, wake_o}, 32'd0);

        // R9 unused bits read zero
        wr(3'd0, 32'hFFFF_FFFF);
        rd("R9 mode readback masked", 3'd0, 32'h07FF_FFFF);
        wr(3'd1, 32'hA5A5_A5A5);
        rd("R9 pol readback", 3'd1, 32'h05A5_A5A5);
        wr(3'd1, 32'd0);

        // latched lines: 10, 12, 24
        wr(3'd0, (32'd1 << 10) | (32'd1 << 12) | (32'd1 << 24));
        wr(3'd2, (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 10) | (32'd1 << 12) | (32'd1 << 24));

        // R2 synchroniser latency on line 3
        ext_ev[3] = 1;
        cyc(1);
        rd("R2 raw after one clock", 3'd4, 32'd0);
        cyc(1);
        rd("R2 raw after two clocks", 3'd4, 32'd1 << 3);
        chk("R3 irq not yet", {31'd0, irq_o}, 32'd0);
        cyc(1);
        chk("R3 direct active high", {31'd0, irq_o}, 32'd1);
        ext_ev[3] = 0;
        cyc(3);
        chk("R3 direct drops with level", {31'd0, irq_o}, 32'd0);
        rd("R10 direct line not pending", 3'd5, 32'd0);

        // R3 active-low on line 5, falling edge on line 24
        wr(3'd1, (32'd1 << 5) | (32'd1 << 24));
        cyc(1);
        chk("R3 direct active low", {31'd0, irq_o}, 32'd1);
        ext_ev[5] = 1;
        cyc(3);
        chk("R3 active low released", {31'd0, irq_o}, 32'd0);

        // R4 one-cycle pulse on latched line 10
        ext_ev[10] = 1;
        cyc(1);
        ext_ev[10] = 0;
        cyc(5);
        rd("R4 pulse latched", 3'd5, 32'd1 << 10);
        chk("R7 irq from pending", {31'd0, irq_o}, 32'd1);
        wr(3'd5, 32'd0);
        rd("R5 zero write keeps pending", 3'd5, 32'd1 << 10);
        wr(3'd5, 32'd1 << 10);
        rd("R5 one write clears", 3'd5, 32'd0);
        chk("R7 irq one clock late", {31'd0, irq_o}, 32'd1);
        cyc(1);
        chk("R7 irq dropped", {31'd0, irq_o}, 32'd0);

        // R4 falling polarity on internal line 24
        int_ev[0] = 1;
        cyc(2);
        rd("R4 wrong edge ignored", 3'd5, 32'd0);
        rd("R2 internal raw direct", 3'd4, (32'd1 << 24) | (32'd1 << 5));
        int_ev[0] = 0;
        cyc(1);
        rd("R4 falling edge latched", 3'd5, 32'd1 << 24);
        wr(3'd5, 32'd1 << 24);
        rd("R5 clear internal", 3'd5, 32'd0);

        // R6 edge and clear together, internal line
        int_ev[0] = 1;
        cyc(2);
        int_ev[0] = 0;
        bus_we = 1; bus_addr = 3'd5; bus_wdata = 32'd1 << 24;
        cyc(1);
        bus_we = 0; bus_wdata = '0;
        rd("R6 internal edge beats clear", 3'd5, 32'd1 << 24);
        wr(3'd5, 32'd1 << 24);

        // R6 edge and clear together, external line 12
        ext_ev[12] = 1;
        cyc(2);
        bus_we = 1; bus_addr = 3'd5; bus_wdata = 32'd1 << 12;
        cyc(1);
        bus_we = 0; bus_wdata = '0;
        rd("R6 external edge beats clear", 3'd5, 32'd1 << 12);
        cyc(1);
        chk("R7 irq from line 12", {31'd0, irq_o}, 32'd1);

        // R7 mask removal, R8 wake path
        wr(3'd2, 32'd0);
        cyc(1);
        chk("R7 masked out", {31'd0, irq_o}, 32'd0);
        wr(3'd3, 32'd1 << 12);
        chk("R8 wake one clock late", {31'd0, wake_o}, 32'd0);
        cyc(1);
        chk("R8 wake asserted", {31'd0, wake_o}, 32'd1);
        wr(3'd5, 32'd1 << 12);
        chk("R8 wake still high", {31'd0, wake_o}, 32'd1);
        cyc(1);
        chk("R8 wake dropped", {31'd0, wake_o}, 32'd0);
        chk("R7 irq stays low", {31'd0, irq_o}, 32'd0);
        rd("R9 unused address", 3'd7, 32'd0);

        cyc(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule